// File: doc/BRIEF.md
# Handshaked Synchronous Single-Port Memory

This block is a small synchronous storage array that serves one access at a time. A requester raises a one-cycle select pulse, and on that clock edge the block captures the address, the write data and the direction control. One edge later the access is carried out. In the cycle after that edge a one-cycle completion strobe is high, and for a read the fetched word is already on the read-data port.

The address, write-data and direction inputs can change freely. Only their values at the select edge count. Select and completion must alternate. A select that arrives while an access is still open is dropped, and the block answers it with a one-cycle protocol-error pulse. Read data is registered and stays unchanged until the next read completes.

Top module: `hs_sync_mem`

## Requirements
- R1: After reset `done`, `protoErr` and `rdData` are all 0 and no access is open.
- R2: The direction bit `rdNotWr` is captured at the select edge. A value of 1 requests a read of the word at `addr`. A value of 0 requests a write of `wrData` to `addr`.
- R3: `done` is high for exactly one cycle for each accepted select.
- R4: A select sampled at clock edge T makes `done` high in the cycle that follows edge T+1. For a read, `rdData` holds the addressed word in that same cycle.
- R5: `addr`, `wrData` and `rdNotWr` are used only as sampled at the select edge. Changes after that edge do not affect the access.
- R6: A select sampled while an access is open (at edge T+1) is ignored and does not modify the memory. `protoErr` is high for one cycle after that edge.
- R7: `rdData` keeps its value until the next read completes. Writes do not change it.
- R8: A select sampled at edge T+2, while `done` is high, is accepted as a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | One-cycle access request |
| rdNotWr | input | 1 | 1 = read, 0 = write, sampled with `sel` |
| addr | input | AW (8) | Word address, sampled with `sel` |
| wrData | input | DW (32) | Write data, sampled with `sel` |
| rdData | output | DW (32) | Registered read data |
| done | output | 1 | One-cycle end-of-access strobe |
| protoErr | output | 1 | One-cycle pulse for a select rejected while busy |

## Verification
The hardest situation to reach from the ports is a select that arrives in the single cycle in which an access is open. Reaching it also requires proving afterwards that the rejected write never reached the array. The stimulus starts a read, raises select again on the very next edge with a write of zero to an address that holds a known word, and checks for the error pulse. A later read of that address confirms the word was kept. The access task also scrambles the address, data and direction right after each select edge, which exercises the capture rule on every access.

// File: rtl/hs_mem_pkg.sv
package hs_mem_pkg;
  // Strobes sent from control to datapath, one per cycle at most
  typedef struct packed {
    logic capture;  // latch address / data at the select edge
    logic doRead;   // perform the read this edge
    logic doWrite;  // perform the write this edge
  } memStrobes_t;
endpackage

// File: rtl/hs_mem_ctrl.sv
module hs_mem_ctrl
  import hs_mem_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sel,
  input  logic        rdNotWr,
  output memStrobes_t strobes,
  output logic        done,
  output logic        protoErr
);
  logic pending;
  logic rwQ;
  logic accept;
  logic reject;

  assign accept = sel && !pending;
  assign reject = sel && pending;

  always_comb begin
    strobes.capture = accept;
    strobes.doRead  = pending && rwQ;
    strobes.doWrite = pending && !rwQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= 1'b0;
      rwQ      <= 1'b0;
      done     <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      done     <= pending;
      protoErr <= reject;
      if (accept) begin
        pending <= 1'b1;
        rwQ     <= rdNotWr;
      end else begin
        pending <= 1'b0;
      end
    end
  end

  // R4: an accepted select opens an access that completes one edge later
  p_accept_opens_r4: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (pending && !done));
  p_pending_completes_r4: assert property (@(posedge clk) disable iff (!rstN)
    pending |=> (done && !pending));
  // R3: completion is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6: a select while busy gives an error pulse and opens nothing
  p_busy_reject_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sel && pending) |=> (protoErr && !pending));
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> !protoErr);
  // R2: at most one operation per edge
  p_one_op_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.doRead, strobes.doWrite}));
endmodule

// File: rtl/hs_mem_datapath.sv
module hs_mem_datapath
  import hs_mem_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  memStrobes_t   strobes,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  localparam int Depth = 1 << AW;

  logic [DW-1:0] mem [Depth];
  logic [AW-1:0] addrQ;
  logic [DW-1:0] dataQ;

  // R5: operands are frozen at the select edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobes.capture) begin
      addrQ <= addr;
      dataQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.doWrite) mem[addrQ] <= dataQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdData <= '0;
    else if (strobes.doRead) rdData <= mem[addrQ];
  end

  // R7: read data only moves on a completing read
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.doRead |=> $stable(rdData));
  // R5: captured operands stay put while an access is open
  p_operands_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(addrQ) && $stable(dataQ)));
endmodule

// File: rtl/hs_sync_mem.sv
module hs_sync_mem
  import hs_mem_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sel,
  input  logic          rdNotWr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          done,
  output logic          protoErr
);
  memStrobes_t strobes;

  hs_mem_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sel      (sel),
    .rdNotWr  (rdNotWr),
    .strobes  (strobes),
    .done     (done),
    .protoErr (protoErr)
  );

  hs_mem_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .addr    (addr),
    .wrData  (wrData),
    .rdData  (rdData)
  );
endmodule

// File: tb/hs_sync_mem_tb.sv
module hs_sync_mem_tb;
  localparam int DW = 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sel = 1'b0;
  logic rdNotWr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic done;
  logic protoErr;

  int nChecks = 0;
  int nFails = 0;
  logic [DW-1:0] lastRead = '0;

  always #4 clk = ~clk;  // 125 MHz

  hs_sync_mem #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rstN(rstN), .sel(sel), .rdNotWr(rdNotWr),
    .addr(addr), .wrData(wrData), .rdData(rdData),
    .done(done), .protoErr(protoErr)
  );

  // {rdNotWr, addr, wrData, expected rdData}
  localparam logic [72:0] VEC [10] = '{
    {1'b0, 8'h00, 32'h1111_1111, 32'h0},
    {1'b0, 8'hFF, 32'hA5A5_A5A5, 32'h0},
    {1'b0, 8'h10, 32'hDEAD_BEEF, 32'h0},
    {1'b1, 8'h00, 32'h0,         32'h1111_1111},
    {1'b1, 8'hFF, 32'h0,         32'hA5A5_A5A5},
    {1'b0, 8'h10, 32'h0BAD_F00D, 32'h0},
    {1'b1, 8'h10, 32'h0,         32'h0BAD_F00D},
    {1'b0, 8'h01, 32'hCAFE_0001, 32'h0},
    {1'b1, 8'h01, 32'h0,         32'hCAFE_0001},
    {1'b1, 8'h00, 32'h0,         32'h1111_1111}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called just after a rising edge; leaves just after the completion edge.
  task automatic doAccess(input logic rw, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [DW-1:0] exp);
    sel = 1'b1; rdNotWr = rw; addr = a; wrData = d;
    @(posedge clk); #1;                      // edge T
    sel = 1'b0; rdNotWr = ~rw; addr = ~a; wrData = ~d;  // R5 scramble
    check("R3 done low in open cycle", {31'b0, done}, 32'd0);
    @(posedge clk); #1;                      // edge T+1
    check("R4 done after completion edge", {31'b0, done}, 32'd1);
    check("R6 no error on clean access", {31'b0, protoErr}, 32'd0);
    if (rw) begin
      lastRead = exp;
      check("R2/R4/R5 read data", rdData, exp);
    end else begin
      check("R7 write leaves rdData", rdData, lastRead);
    end
  endtask

  initial begin
    #(8 * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 done reset", {31'b0, done}, 32'd0);
    check("R1 protoErr reset", {31'b0, protoErr}, 32'd0);
    check("R1 rdData reset", rdData, 32'd0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // Table walk; consecutive accesses start while done is high (R8)
    for (int i = 0; i < 10; i++) begin
      doAccess(VEC[i][72], VEC[i][71:64], VEC[i][63:32], VEC[i][31:0]);
    end

    // R3: idle cycle after the last completion
    @(posedge clk); #1;
    check("R3 done single cycle", {31'b0, done}, 32'd0);

    // R6: read 0xFF, then select again at T+1 with a write of 0 to 0x00
    sel = 1'b1; rdNotWr = 1'b1; addr = 8'hFF; wrData = '0;
    @(posedge clk); #1;                      // T
    sel = 1'b1; rdNotWr = 1'b0; addr = 8'h00; wrData = 32'h0;
    @(posedge clk); #1;                      // T+1, select while busy
    sel = 1'b0;
    check("R6 protoErr on busy select", {31'b0, protoErr}, 32'd1);
    check("R4 done for first access", {31'b0, done}, 32'd1);
    check("R4 read data 0xFF", rdData, 32'hA5A5_A5A5);
    lastRead = 32'hA5A5_A5A5;
    @(posedge clk); #1;
    check("R6 protoErr single cycle", {31'b0, protoErr}, 32'd0);
    check("R6 rejected select gives no done", {31'b0, done}, 32'd0);
    check("R7 rdData held while idle", rdData, 32'hA5A5_A5A5);
    doAccess(1'b1, 8'h00, 32'h0, 32'h1111_1111);  // R6 memory untouched

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule